// File: doc/BRIEF.md
# Pipelined Two-Level Code-to-One-Hot Decoder

This block expands an 8-bit binary code into a 256-bit word in which exactly one bit is set. It is built to run at a high clock rate, so a register stands after every level of logic. The incoming code is captured first. Each half of the code then feeds its own 4-to-16 predecoder, and both predecoder results are registered. Every output bit is the AND of one line from the high predecoder and one line from the low predecoder, and a final register drives the output.

The output uses reversed bit order: code 0 lights bit 255 and code 255 lights bit 0. A valid flag passes through the same three register stages as the data, so the flag and its word always leave together. A new code may be presented on every clock, and there are no stalls.

Top module: `onehot_pipe_dec`

## Requirements
- R1: For every code value c in 0..255, the output word carries exactly one set bit, and that bit sits at index 255 - c.
- R2: The output word and the output valid appear exactly 3 clock edges after the code and the input valid are sampled.
- R3: The output valid equals the input valid delayed by exactly 3 clock edges.
- R4: Codes presented on consecutive cycles produce one word each on consecutive cycles, each word belonging only to its own code, so there is one decode per clock.
- R5: A synchronous active-high reset clears every data and valid register. While the output valid is low after reset, the output word is all zeros.
- R6: A code presented with the input valid low produces an all-zero output word 3 cycles later, with the output valid low.
- R7: The high nibble (bits 7:4) selects the output group 15 - hi, and the low nibble (bits 3:0) selects the position 15 - lo inside that group. The output index is 16*(15-hi) + (15-lo).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Qualifies in_code on this cycle |
| in_code | input | 8 | Binary code to decode |
| out_vld | output | 1 | Qualifies out_word |
| out_word | output | 256 | Reversed-order one-hot result |

## Verification
Each result is due 3 rising edges after its stimulus: one edge for the input register, one for the predecoder register and one for the AND-stage register. The bench drives a code just after a falling edge and keeps a model queue three entries deep. On every following cycle it samples at the falling edge, so every word is compared against the model entry that the pipeline depth makes due in that cycle. Streams of back-to-back codes, gaps in valid, and resets in the middle of a stream are all checked with this same alignment.

// File: rtl/onehot_pipe_pkg.sv
package onehot_pipe_pkg;
  localparam int unsigned CODE_W = 8;
  localparam int unsigned HALF_W = CODE_W / 2;
  localparam int unsigned LINES  = 1 << HALF_W;
  localparam int unsigned OUT_W  = 1 << CODE_W;
  localparam int unsigned DEPTH  = 3;

  typedef struct packed {
    logic              vld;
    logic [CODE_W-1:0] code;
  } code_stage_t;

  typedef struct packed {
    logic             vld;
    logic [LINES-1:0] hi;
    logic [LINES-1:0] lo;
  } pre_stage_t;

  // Reversed-order index: code 0 maps to the top bit.
  function automatic int unsigned rev_index(input logic [CODE_W-1:0] c);
    return (OUT_W - 1) - int'(c);
  endfunction

  // Reversed-order one-hot predecode of one nibble.
  function automatic logic [LINES-1:0] nibble_lines(input logic [HALF_W-1:0] n);
    logic [LINES-1:0] r;
    r = '0;
    r[(LINES-1) - int'(n)] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/onehot_in_reg.sv
module onehot_in_reg
  import onehot_pipe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              d_vld,
  input  logic [CODE_W-1:0] d_code,
  output code_stage_t       q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      q.vld  <= d_vld;
      q.code <= d_code;
    end
  end
endmodule

// File: rtl/onehot_predec.sv
module onehot_predec
  import onehot_pipe_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  code_stage_t s_in,
  output pre_stage_t  s_out
);
  logic [LINES-1:0] hi_comb, lo_comb;

  always_comb begin
    hi_comb = nibble_lines(s_in.code[CODE_W-1:HALF_W]);
    lo_comb = nibble_lines(s_in.code[HALF_W-1:0]);
    if (!s_in.vld) begin
      hi_comb = '0;
      lo_comb = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_out <= '0;
    end else begin
      s_out.vld <= s_in.vld;
      s_out.hi  <= hi_comb;
      s_out.lo  <= lo_comb;
    end
  end

  // R7: each registered predecoder output holds at most one line.
  assert_pre_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(s_out.hi) && $onehot0(s_out.lo));
  // R6: an invalid input leaves both predecoders empty.
  assert_pre_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !s_in.vld |=> (s_out.hi == '0) && (s_out.lo == '0));
endmodule

// File: rtl/onehot_and_stage.sv
module onehot_and_stage
  import onehot_pipe_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  pre_stage_t       s_in,
  output logic             q_vld,
  output logic [OUT_W-1:0] q_word
);
  logic [OUT_W-1:0] and_comb;

  // Bit 16*g + p is the AND of high line g and low line p.
  for (genvar g = 0; g < LINES; g++) begin : g_grp
    for (genvar p = 0; p < LINES; p++) begin : g_pos
      assign and_comb[g*LINES + p] = s_in.hi[g] & s_in.lo[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_vld  <= 1'b0;
      q_word <= '0;
    end else begin
      q_vld  <= s_in.vld;
      q_word <= and_comb;
    end
  end
endmodule

// File: rtl/onehot_pipe_dec.sv
module onehot_pipe_dec
  import onehot_pipe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_vld,
  output logic [OUT_W-1:0]  out_word
);
  code_stage_t st1;
  pre_stage_t  st2;

  onehot_in_reg u_in (
    .clk(clk), .rst(rst), .d_vld(in_vld), .d_code(in_code), .q(st1)
  );

  onehot_predec u_pre (
    .clk(clk), .rst(rst), .s_in(st1), .s_out(st2)
  );

  onehot_and_stage u_and (
    .clk(clk), .rst(rst), .s_in(st2), .q_vld(out_vld), .q_word(out_word)
  );

  // Reset-age counter so the $past look-backs stay inside the cycles since reset.
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  logic primed;
  assign primed = (age == 2'd3);

  // R1: a valid output carries exactly one set bit.
  assert_one_bit_R1: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $countones(out_word) == 1);
  // R5: with the output valid low, the output word is empty.
  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> out_word == '0);
  // R3: the output valid is the input valid delayed by three edges.
  assert_vld_delay_R3: assert property (@(posedge clk) disable iff (rst)
    primed |-> out_vld == $past(in_vld, 3));
  // R2: the set bit matches the code sampled three edges earlier.
  assert_word_delay_R2: assert property (@(posedge clk) disable iff (rst)
    (primed && out_vld) |-> out_word[rev_index($past(in_code, 3))]);
endmodule

// File: tb/onehot_pipe_dec_bench.sv
module onehot_pipe_dec_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_vld;
  logic [7:0]   in_code;
  logic         out_vld;
  logic [255:0] out_word;

  int checks = 0;
  int errors = 0;
  logic         mv [0:2];
  logic [255:0] mw [0:2];

  always #5 clk = ~clk;

  onehot_pipe_dec u_onehot_pipe_dec (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_code(in_code),
    .out_vld(out_vld), .out_word(out_word)
  );

  // Expected word built from the nibble rule (group 15-hi, position 15-lo).
  function automatic logic [255:0] expect_word(input logic v, input logic [7:0] c);
    logic [255:0] w;
    w = '0;
    if (v) w[16*(15 - int'(c[7:4])) + (15 - int'(c[3:0]))] = 1'b1;
    return w;
  endfunction

  task automatic check(input string req, input logic v, input logic [255:0] w);
    checks++;
    if (out_vld !== v || out_word !== w) begin
      errors++;
      $display("FAIL %s: got vld=%0b word=%h expected vld=%0b word=%h",
               req, out_vld, out_word, v, w);
    end
  endtask

  // One cycle: drive after the falling edge, advance the model, check the due entry.
  task automatic step(input string req, input logic v, input logic [7:0] c);
    in_vld  = v;
    in_code = c;
    @(posedge clk);
    mv[2] = mv[1]; mw[2] = mw[1];
    mv[1] = mv[0]; mw[1] = mw[0];
    mv[0] = v;     mw[0] = expect_word(v, c);
    @(negedge clk);
    check(req, mv[2], mw[2]);
  endtask

  task automatic do_reset();
    rst = 1'b1; in_vld = 1'b0; in_code = '0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) begin mv[i] = 1'b0; mw[i] = '0; end
    check("R5", 1'b0, '0);
  endtask

  task automatic t_corners();
    step("R1", 1'b1, 8'd0);
    step("R1", 1'b1, 8'd255);
    step("R7", 1'b1, 8'h0F);
    step("R2", 1'b1, 8'hF0);
    step("R2", 1'b0, 8'h00);
    step("R2", 1'b0, 8'h00);
    step("R1", 1'b0, 8'h00);
    // Direct index checks at the corners.
    checks++;
    if (expect_word(1'b1, 8'd0) !== (256'b1 << 255)) begin
      errors++; $display("FAIL R1: model top bit mismatch");
    end
  endtask

  task automatic t_sweep();
    for (int c = 0; c < 256; c++) step("R4", 1'b1, 8'(c));
    for (int i = 0; i < 3; i++) step("R4", 1'b0, 8'h00);
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 40; i++)
      step("R3", ((i % 3) != 1), 8'((i * 37 + 11) & 8'hFF));
    for (int i = 0; i < 10; i++) step("R6", 1'b0, 8'((i * 29) & 8'hFF));
    for (int i = 0; i < 3; i++) step("R6", 1'b0, 8'h00);
  endtask

  task automatic t_midreset();
    step("R4", 1'b1, 8'h5A);
    step("R4", 1'b1, 8'hA5);
    do_reset();
    for (int i = 0; i < 3; i++) step("R5", 1'b0, 8'h77);
    step("R5", 1'b1, 8'h3C);
    for (int i = 0; i < 3; i++) step("R2", 1'b0, 8'h00);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        do_reset();
        t_corners();
        t_sweep();
        t_gaps();
        t_midreset();
      end
      begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule